// File: doc/BRIEF.md
# Dual-Supply Master Reset Sequencer

This block turns the supply-monitor flags of two power domains, one analog and one digital, into the single master reset used by the rest of a chip. Each domain supplies a coarse and a fine comparator flag. The comparators and their hysteresis sit outside the block. A domain counts as good only while both of its flags are high. The chip is powered when both domains are good at the same time.

While the chip is not powered, the master reset is held asserted with no clock involved. Once both domains are good, the power-good level passes through a two-flop synchroniser. A hold counter then runs for a programmed interval, 130 ms at the nominal clock by default, before reset is released. If either domain loses a flag at any point, reset is asserted again at once and the interval starts over. A pending output shows that power is good but the hold interval has not yet run out.

Top module: `sup_rst_seq`

## Requirements
- R1: `rst_no` is low whenever either domain is not good, with no clock edge needed.
- R2: A domain is good only while its coarse flag and its fine flag are both high. A fine flag without its coarse flag, or a coarse flag without its fine flag, never allows reset to release.
- R3: Take the first rising clock edge at which both domains are good as edge 1. If both stay good, `rst_no` goes high at edge HOLD_CYCLES+2 and stays low before that edge. HOLD_CYCLES = CLK_KHZ*HOLD_MS.
- R4: A drop of either fine flag after release drives `rst_no` low before the next clock edge.
- R5: If power-good is lost during the hold interval, the count is discarded. The full HOLD_CYCLES+2 edges are counted again from the next power-good.
- R6: `pending_o` is high exactly while both domains are good and `rst_no` is still low. It is low when power is not good and after release.
- R7: A drop of either coarse flag after release asserts `rst_no` at once, in the same way as a fine-flag drop.
- R8: Once released, `rst_no` stays high for as long as both domains remain good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| ana_coarse_i | input | 1 | Analog domain coarse supply-good flag |
| ana_fine_i | input | 1 | Analog domain fine supply-good flag |
| dig_coarse_i | input | 1 | Digital domain coarse supply-good flag |
| dig_fine_i | input | 1 | Digital domain fine supply-good flag |
| rst_no | output | 1 | Master reset, active low |
| pending_o | output | 1 | Power good, hold interval still running |

## Verification
The hardest situations to create are the ones that happen between clock edges. These are a brownout that must pull reset low with no edge in between, and a power-good loss partway through the hold window that must throw away a partial count. The bench changes flags just after a falling edge and samples `rst_no` one nanosecond later, before any rising edge. It drops power-good at the midpoint of the hold window, then restores it and checks that release comes only after a full fresh interval. A reference model counts consecutive powered edges and compares both outputs on every cycle.

// File: rtl/sup_rst_pkg.sv
`timescale 1ns/1ps
package sup_rst_pkg;
  localparam int unsigned NUM_DOM = 2;
  localparam int unsigned DOM_ANA = 0;
  localparam int unsigned DOM_DIG = 1;

  typedef struct packed {
    logic coarse;
    logic fine;
  } sup_flag_t;
endpackage

// File: rtl/sup_dom_qual.sv
`timescale 1ns/1ps
module sup_dom_qual
  import sup_rst_pkg::*;
(
  input  sup_flag_t flag_i,
  output logic      good_o
);
  // fine comparator is only trusted once coarse has tripped
  assign good_o = flag_i.coarse & flag_i.fine;
endmodule

// File: rtl/sup_sync2.sv
`timescale 1ns/1ps
module sup_sync2 (
  input  logic clk_i,
  input  logic clr_ni,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;

  // R3
  sync_order_chk: assert property (@(posedge clk_i) disable iff (!clr_ni)
    s2_q |-> s1_q);
endmodule

// File: rtl/sup_hold_timer.sv
`timescale 1ns/1ps
module sup_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 32_500_000
) (
  input  logic clk_i,
  input  logic clr_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i && !done_q) begin
      if (cnt_q == LAST) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done_o = done_q;

  // R8
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!clr_ni)
    done_q |=> done_q);
  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!clr_ni)
    cnt_q <= LAST);
  // R5
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!clr_ni)
    !start_i |-> (cnt_q == '0 && !done_q));
endmodule

// File: rtl/sup_rst_seq.sv
`timescale 1ns/1ps
module sup_rst_seq
  import sup_rst_pkg::*;
#(
  parameter int unsigned CLK_KHZ = 250_000,
  parameter int unsigned HOLD_MS = 130
) (
  input  logic clk_i,
  input  logic ana_coarse_i,
  input  logic ana_fine_i,
  input  logic dig_coarse_i,
  input  logic dig_fine_i,
  output logic rst_no,
  output logic pending_o
);
  localparam int unsigned HOLD_CYCLES = CLK_KHZ * HOLD_MS;

  sup_flag_t [NUM_DOM-1:0] flags;
  logic      [NUM_DOM-1:0] dom_good;
  logic pg, pg_sync, done;

  assign flags[DOM_ANA] = '{coarse: ana_coarse_i, fine: ana_fine_i};
  assign flags[DOM_DIG] = '{coarse: dig_coarse_i, fine: dig_fine_i};

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    sup_dom_qual u_qual (
      .flag_i (flags[d]),
      .good_o (dom_good[d])
    );
  end

  // doubles as asynchronous clear for all sequencing state
  assign pg = &dom_good;

  sup_sync2 u_sync (
    .clk_i  (clk_i),
    .clr_ni (pg),
    .q_o    (pg_sync)
  );

  sup_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .clr_ni  (pg),
    .start_i (pg_sync),
    .done_o  (done)
  );

  assign rst_no    = done;
  assign pending_o = pg & ~done;

  // R1
  pg_low_rst_chk: assert property (@(posedge clk_i)
    !pg |-> !rst_no);
  // R6
  release_pending_chk: assert property (@(posedge clk_i) disable iff (!pg)
    $rose(rst_no) |-> $past(pending_o));
endmodule

// File: tb/sup_rst_seq_bench.sv
`timescale 1ns/1ps
module sup_rst_seq_bench;
  localparam int unsigned KHZ = 10;
  localparam int unsigned MS  = 2;
  localparam int N = KHZ * MS;

  logic clk = 1'b0;
  logic ac = 1'b0, af = 1'b0, dc = 1'b0, df = 1'b0;
  logic rst_n, pend;
  int tests = 0, fails = 0;
  int k = 0;

  always #2 clk = ~clk;

  sup_rst_seq #(.CLK_KHZ(KHZ), .HOLD_MS(MS)) u_sup_rst_seq (
    .clk_i(clk), .ana_coarse_i(ac), .ana_fine_i(af),
    .dig_coarse_i(dc), .dig_fine_i(df), .rst_no(rst_n), .pending_o(pend));

  function automatic logic pg_m();
    return ac && af && dc && df;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // model: consecutive powered edges; compare at negedge
  task automatic cyc();
    @(posedge clk);
    k = pg_m() ? k + 1 : 0;
    @(negedge clk);
    chk(pg_m() ? "R3" : "R1", rst_n, pg_m() && (k >= N + 2));
    chk("R6", pend, pg_m() && !(k >= N + 2));
  endtask

  task automatic set(input logic a_c, a_f, d_c, d_f);
    ac = a_c; af = a_f; dc = d_c; df = d_f;
    if (!pg_m()) k = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1", rst_n, 1'b0);
    chk("R6", pend, 1'b0);
    // R2: incomplete flag sets never release
    set(1, 0, 1, 1); run(N + 5); chk("R2", rst_n, 1'b0);
    set(0, 1, 1, 1); run(N + 5); chk("R2", rst_n, 1'b0);
    set(1, 1, 0, 1); run(N + 5); chk("R2", rst_n, 1'b0);
    set(1, 1, 1, 0); run(N + 5); chk("R2", rst_n, 1'b0);
    // R3: exact release edge
    set(1, 1, 1, 1);
    run(N + 1); chk("R3", rst_n, 1'b0); chk("R6", pend, 1'b1);
    run(1);     chk("R3", rst_n, 1'b1); chk("R6", pend, 1'b0);
    // R8: stays released
    run(15); chk("R8", rst_n, 1'b1);
    // R4: analog fine brownout, no clock edge
    set(1, 0, 1, 1); #1; chk("R4", rst_n, 1'b0); chk("R6", pend, 1'b0);
    run(3);
    set(1, 1, 1, 1); run(N + 4); chk("R8", rst_n, 1'b1);
    // R4: digital fine brownout
    set(1, 1, 1, 0); #1; chk("R4", rst_n, 1'b0);
    run(2);
    // R5: loss mid-hold restarts the count
    set(1, 1, 1, 1); run(N / 2); chk("R5", pend, 1'b1);
    set(1, 1, 0, 1); #1; chk("R5", pend, 1'b0);
    run(1);
    set(1, 1, 1, 1);
    run(N + 1); chk("R5", rst_n, 1'b0);
    run(1);     chk("R5", rst_n, 1'b1);
    // R7: coarse drop acts at once
    set(0, 1, 1, 1); #1; chk("R7", rst_n, 1'b0);
    run(2);
    set(1, 1, 1, 1); run(N + 3);
    set(1, 1, 0, 1); #1; chk("R7", rst_n, 1'b0);
    run(2);
    // single-cycle glitch during hold
    set(1, 1, 1, 1); run(3);
    set(1, 1, 1, 0); run(1);
    set(1, 1, 1, 1); run(N + 4); chk("R5", rst_n, 1'b1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule